// File: doc/BRIEF.md
# Double-Data-Rate Word Serializer

This block turns 8-bit parallel words produced by system logic into a single serial stream that carries two bits per fast-clock period, one while the fast clock is high and one while it is low. A word is captured on the rising edge of the word clock. The fast clock runs at four times the word rate, and a two-state sequencer in the fast domain moves the captured word into two 4-bit lane shifters. One lane takes the even bits and the other takes the odd bits. The shifters then send their most significant bit out on each enabled fast edge.

A small output stage registers the two lane bits on every enabled fast edge. It then uses the fast clock level to choose which of the two bits drives the serial pin. The fast clock and the word clock are expected to come from one source with rising edges that coincide. Clock generation itself is outside the block. A clock enable freezes the whole fast-domain pipeline.

The sequencer has two states. PH_LOAD asserts the parallel load. On an enabled edge it always moves to PH_SHIFT and clears its shift count. PH_SHIFT lets both lanes shift left. It stays in PH_SHIFT for three enabled edges, counting them. On the third it returns to PH_LOAD.

Top module: `ddr_word_serializer`

## Requirements
- R1: Word bits 0, 2, 4 and 6 travel in the high lane (sent while clk_fast is high), and bits 1, 3, 5 and 7 travel in the low lane (sent while clk_fast is low). A word of 8'h55 therefore yields a stream of high halves at 1 and low halves at 0.
- R2: The word is captured into a holding register only on a rising edge of clk_word. Values that word_in takes between those edges have no effect on the stream. clk_en does not gate this capture.
- R3: After reset the sequencer is in PH_LOAD. The lanes load in parallel on the first enabled fast edge after reset and then on every fourth enabled fast edge. On all other enabled edges the lanes shift left.
- R4: Each word is sent in the order bit6, bit7, bit4, bit5, bit2, bit3, bit0, bit1, which means each lane sends its most significant bit first.
- R5: ser_out equals the registered high-lane bit while clk_fast is high and the registered low-lane bit while clk_fast is low.
- R6: An active-high synchronous rst clears the holding register, the sequencer, both lanes and both output registers. ser_out is then low until a loaded word reaches the output.
- R7: Words captured on consecutive clk_word edges come out back to back with no idle half-periods. With clock enable held high, the first bit of a word captured at a word-clock edge that coincides with a load edge appears in the high half that follows the fifth fast edge after that capture.
- R8: While clk_en is low on a fast edge, the sequencer, both lanes and both output registers keep their values. ser_out therefore keeps repeating the same high/low pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Bit clock at four times the word rate; both edges carry data |
| clk_word | input | 1 | Word clock; its rising edge captures word_in |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Fast-domain enable; low freezes the serializer |
| word_in | input | 8 | Parallel word from system logic |
| ser_out | output | 1 | Double-data-rate serial output |

## Verification
A word captured at a word-clock edge reaches the lanes at the next load edge. Its first pair is registered one enabled fast edge after that load, and the following pairs come on each later enabled edge. So every fast edge sets the pair for the high half and the low half that follow it. The bench keeps a reference model that it advances on each fast rising edge from the inputs it drove half a period earlier. It compares ser_out 1.25 ns into the high half and again 1.25 ns into the low half, so each check falls inside the half-period it is meant to observe. Stretches with the enable low, a mid-run reset and words that change on every fast cycle shift the load phase against the word clock. The model follows these shifts by counting enabled edges rather than time.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;

    // Sequencer states: parallel load, then lane shifting
    typedef enum logic {
        PH_LOAD  = 1'b0,
        PH_SHIFT = 1'b1
    } ser_phase_e;

    // Number of lanes in the double-data-rate output (one per clock level)
    localparam int SER_LANES = 2;

endpackage

// File: rtl/ser_phase_ctrl.sv
`timescale 1ns/1ps
module ser_phase_ctrl
    import ser_pkg::*;
#(
    parameter int DEPTH = 4   // lane length, must be at least 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic load
);

    localparam int CW = (DEPTH > 2) ? $clog2(DEPTH - 1) : 1;
    localparam logic [CW-1:0] LAST_SHIFT = CW'(DEPTH - 2);

    ser_phase_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_LOAD;
            cnt_q   <= '0;
        end else if (en) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: one load edge followed by DEPTH-1 shift edges
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_LOAD: begin
                state_d = PH_SHIFT;
                cnt_d   = '0;
            end
            PH_SHIFT: begin
                if (cnt_q == LAST_SHIFT) begin
                    state_d = PH_LOAD;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        load = (state_q == PH_LOAD);
    end

endmodule

// File: rtl/ser_lane_shifter.sv
`timescale 1ns/1ps
module ser_lane_shifter #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [DEPTH-1:0] par_in,
    output logic             msb_out
);

    logic [DEPTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (en) begin
            if (load) begin
                sr_q <= par_in;
            end else begin
                sr_q <= {sr_q[DEPTH-2:0], 1'b0};
            end
        end
    end

    assign msb_out = sr_q[DEPTH-1];

endmodule

// File: rtl/ser_ddr_out.sv
`timescale 1ns/1ps
module ser_ddr_out (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic hi_in,
    input  logic lo_in,
    output logic hi_q,
    output logic lo_q,
    output logic ser_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else if (en) begin
            hi_q <= hi_in;
            lo_q <= lo_in;
        end
    end

    // Clock level picks the lane: high half carries hi_q, low half lo_q
    assign ser_out = clk ? hi_q : lo_q;

endmodule

// File: rtl/ddr_word_serializer.sv
`timescale 1ns/1ps
module ddr_word_serializer
    import ser_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk_fast,
    input  logic              clk_word,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              ser_out
);

    localparam int DEPTH = WORD_W / SER_LANES;

    logic [WORD_W-1:0]                  hold_q;
    logic                               load;
    logic [SER_LANES-1:0][DEPTH-1:0]    lane_par;
    logic [SER_LANES-1:0]               lane_msb;
    logic                               hi_q, lo_q;

    // Word-domain capture register (not gated by clk_en)
    always_ff @(posedge clk_word) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= word_in;
        end
    end

    ser_phase_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk  (clk_fast),
        .rst  (rst),
        .en   (clk_en),
        .load (load)
    );

    // Lane 0 takes even bits, lane 1 odd bits; highest bit at the MSB
    for (genvar g = 0; g < SER_LANES; g++) begin : g_lane
        for (genvar j = 0; j < DEPTH; j++) begin : g_bit
            assign lane_par[g][j] = hold_q[SER_LANES*j + g];
        end
        ser_lane_shifter #(.DEPTH(DEPTH)) u_shift (
            .clk     (clk_fast),
            .rst     (rst),
            .en      (clk_en),
            .load    (load),
            .par_in  (lane_par[g]),
            .msb_out (lane_msb[g])
        );
    end

    ser_ddr_out u_out (
        .clk     (clk_fast),
        .rst     (rst),
        .en      (clk_en),
        .hi_in   (lane_msb[0]),
        .lo_in   (lane_msb[1]),
        .hi_q    (hi_q),
        .lo_q    (lo_q),
        .ser_out (ser_out)
    );

endmodule

// File: rtl/ddr_word_serializer_chk.sv
`timescale 1ns/1ps
module ddr_word_serializer_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk_fast,
    input logic              rst,
    input logic              clk_en,
    input logic              load,
    input logic [WORD_W-1:0] hold_q,
    input logic              hi_q,
    input logic              lo_q,
    input logic              ser_out
);

    localparam int DEPTH = WORD_W / 2;
    localparam int CW    = $clog2(DEPTH);

    // Independent count of enabled edges since reset, modulo DEPTH
    logic [CW-1:0] chk_cnt;
    always_ff @(posedge clk_fast) begin
        if (rst) begin
            chk_cnt <= '0;
        end else if (clk_en) begin
            chk_cnt <= (chk_cnt == CW'(DEPTH - 1)) ? '0 : chk_cnt + 1'b1;
        end
    end

    // R3: load strobe on the first enabled edge and every DEPTH-th after
    a_r3_load_cadence: assert property (@(posedge clk_fast) disable iff (rst)
        load == (chk_cnt == '0));

    // R8: a disabled edge changes nothing in the fast domain
    a_r8_hold: assert property (@(posedge clk_fast) disable iff (rst)
        !clk_en |=> ($stable(hi_q) && $stable(lo_q) && $stable(load)));

    // R6: leaving reset, outputs are clear and a load is pending
    a_r6_reset_clear: assert property (@(posedge clk_fast) disable iff (rst)
        $fell(rst) |-> (hi_q == 1'b0 && lo_q == 1'b0 && load));

    // R5: low half drives the low-lane register, high half the high-lane one
    a_r5_mux_low: assert property (@(posedge clk_fast) disable iff (rst)
        ser_out == lo_q);
    a_r5_mux_high: assert property (@(negedge clk_fast) disable iff (rst)
        ser_out == hi_q);

    // R4: the pair after a load carries the top even and top odd bits
    a_r4_msb_first: assert property (@(posedge clk_fast) disable iff (rst)
        ($past(!rst && clk_en && load) && clk_en) |=>
            (hi_q == $past(hold_q[WORD_W-2], 2) && lo_q == $past(hold_q[WORD_W-1], 2)));

endmodule

bind ddr_word_serializer ddr_word_serializer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk_fast (clk_fast),
    .rst      (rst),
    .clk_en   (clk_en),
    .load     (load),
    .hold_q   (hold_q),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .ser_out  (ser_out)
);

// File: tb/ddr_word_serializer_test.sv
`timescale 1ns/1ps
module ddr_word_serializer_test;

    logic       clk_fast, clk_word, rst, clk_en;
    logic [7:0] word_in;
    logic       ser_out;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string cur_tag = "R6";

    ddr_word_serializer uut (
        .clk_fast (clk_fast),
        .clk_word (clk_word),
        .rst      (rst),
        .clk_en   (clk_en),
        .word_in  (word_in),
        .ser_out  (ser_out)
    );

    // 200 MHz fast clock; word clock at a quarter rate, rising edges aligned
    initial begin
        clk_fast = 0;
        clk_word = 0;
        for (int t = 0; ; t++) begin
            #2.5;
            if (t % 4 == 0) clk_word = 1;
            else if (t % 4 == 2) clk_word = 0;
            clk_fast = 1;
            #2.5;
            clk_fast = 0;
        end
    end

    // Pair sent after an edge at the given position of the word (R4 order)
    function automatic logic [1:0] pair_bits(input logic [7:0] w, input int p);
        case (p)
            1:       return {w[6], w[7]};
            2:       return {w[4], w[5]};
            3:       return {w[2], w[3]};
            default: return {w[0], w[1]};
        endcase
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: ser_out actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference model, advanced at each fast rising edge
    int         e_cnt   = 0;
    int         m_phase = 0;
    logic [7:0] m_word  = '0;
    logic [7:0] m_hold  = '0;
    logic       m_hi    = 0;
    logic       m_lo    = 0;

    always @(posedge clk_fast) begin
        logic [1:0] pr;
        string      tag;
        tag = cur_tag;
        if (rst) begin
            m_phase = 0;
            m_word  = '0;
            m_hi    = 0;
            m_lo    = 0;
        end else if (clk_en) begin
            pr      = pair_bits(m_word, m_phase);
            m_hi    = pr[1];
            m_lo    = pr[0];
            if (m_phase == 0) m_word = m_hold;
            m_phase = (m_phase + 1) % 4;
        end
        if (e_cnt % 4 == 0) m_hold = rst ? 8'h00 : word_in;
        e_cnt++;
        #1.25;
        if (!done) check(tag, ser_out, m_hi);
        #2.5;
        if (!done) check((tag == "R4") ? "R5" : tag, ser_out, m_lo);
    end

    task automatic run(input string tag, input int n, input int mode);
        cur_tag = tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_fast);
            case (mode)
                0: ;                                           // word held
                1: word_in = 8'($urandom);                     // every cycle
                2: if (i % 4 == 0) word_in = 8'($urandom);     // once per word
                default: begin
                    word_in = 8'($urandom);
                    clk_en  = ($urandom % 2) == 0;
                end
            endcase
        end
        @(negedge clk_fast);
        clk_en = 1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; clk_en = 1; word_in = 8'h00;
        cur_tag = "R6";
        repeat (8) @(negedge clk_fast);
        rst = 0;
        word_in = 8'h55;  run("R1", 24, 0);      // even bits high, odd low
        word_in = 8'hAA;  run("R1", 24, 0);
        word_in = 8'h80;  run("R4", 16, 0);      // single top odd bit
        run("R7", 200, 2);                        // back-to-back distinct words
        run("R2", 200, 1);                        // word changes between captures
        run("R4", 400, 1);
        run("R8", 300, 3);                        // enable toggling
        run("R3", 300, 3);                        // load cadence counts enabled edges
        cur_tag = "R6";
        rst = 1;
        repeat (8) @(negedge clk_fast);
        rst = 0;
        word_in = 8'h01;  run("R6", 12, 0);      // low until a loaded word arrives
        run("R4", 60, 1);
        #10;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog (R1..R8 run): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule